// File: doc/BRIEF.md
# Bidirectional Parallel Port with Direction Control

This block is an N-bit general-purpose I/O port on a small register bus. It keeps two pieces of state: a direction mask with one bit per pin, and an output latch. Each pin has an output value and an output enable that go to an external tri-state pad, and an input level that comes back from the pad. Software sets the direction mask, writes the latch, and reads back a port value that mixes the live pin levels with the latched values.

Two copies of the block can share one bus. Parameter `PORT_IDX` moves both registers of a copy by one address, so port 0 answers at 0x0000 (data) and 0x0004 (direction) and port 1 answers at 0x0001 and 0x0005. Every copy ignores all other addresses.

A two-state read controller produces the response. In `ST_IDLE` it waits. An accepted read (the transition `GO_RESP`) loads the read data register and enters `ST_RESP`, where `bus_rvalid` is high for that cycle. From `ST_RESP`, a new read gives `STAY_RESP`, and anything else gives `BACK_IDLE` to `ST_IDLE`. Writes never leave `ST_IDLE`.

Top module: `gpio_port`

## Requirements
- R1: While `rst` is high, every direction bit is cleared to 0. All pins then have `pin_oe` = 0 and `bus_rvalid` = 0.
- R2: A write to the direction address stores `bus_wdata`. Bit i = 1 makes pin i an output and bit i = 0 makes it an input. `pin_oe` shows the new mask in the cycle after the write edge.
- R3: A write to the data address always loads the output latch, including bits whose pins are inputs. `pin_out` always presents the latch.
- R4: A read of the data address returns the latch value for bits with direction 1 and the synchronized pin level for bits with direction 0.
- R5: A read of the direction address returns the stored direction mask.
- R6: The data register is at DATA_BASE+PORT_IDX (0x0000 or 0x0001), and the direction register is at DIR_BASE+PORT_IDX (0x0004 or 0x0005). Any other address does not change `pin_out` or `pin_oe` and gives no response.
- R7: `bus_rvalid` is high in exactly the cycle after each accepted read, so back-to-back reads give back-to-back responses. A write produces no response.
- R8: Pin inputs pass through two flip-flop stages. After a pin changes, reads accepted at the first and second rising edges return the old level. A read accepted at the third edge returns the new level.
- R9: Reset does not change the output latch. `pin_out` keeps its value across a reset pulse.
- R10: When a bit changes from input to output, its pin drives the value already in the latch, with no extra write needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data, valid while `bus_rvalid` is high |
| bus_rvalid | output | 1 | Read response strobe |
| pin_in | input | W | Pad input levels |
| pin_out | output | W | Pad output values (the latch) |
| pin_oe | output | W | Pad output enables (the direction mask) |

## Verification
The bench builds two copies on one shared bus, one with `PORT_IDX` = 0 and one with `PORT_IDX` = 1, both at the default width of 8 and address width of 13. With two copies present, the bench can show that each copy decodes only its own address pair, and that an address one copy ignores does not leak into the other. Keeping the width at 8 makes the mixed read patterns easy to predict, such as a 0xF0 mask over a 0x3C latch and pin levels of 0xA5. The two-stage input delay is checked with three back-to-back reads issued at the same moment a pin changes.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DATA = 2'd1,
        SEL_DIR  = 2'd2
    } reg_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rd_state_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) chain[0] <= d;

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) chain[s] <= chain[s-1];
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_data,
    input  logic         wr_dir,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] latch_q,
    output logic [W-1:0] dir_q
);
    // Output latch: no reset on purpose (R9)
    always_ff @(posedge clk) begin
        if (wr_data) latch_q <= wdata;
    end

    // Direction mask: cleared by reset (R1)
    always_ff @(posedge clk) begin
        if (rst)         dir_q <= '0;
        else if (wr_dir) dir_q <= wdata;
    end

    p_latch_load_r3: assert property (@(posedge clk) disable iff (rst)
        wr_data |=> latch_q == $past(wdata))
        else $error("latch did not take written value");
endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux
    import gpio_pkg::*;
#(
    parameter int W = 8
) (
    input  reg_sel_e     sel,
    input  logic [W-1:0] latch_q,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] pin_sync,
    output logic [W-1:0] rd_value
);
    always_comb begin
        unique case (sel)
            SEL_DIR:  rd_value = dir_q;
            SEL_DATA: rd_value = (dir_q & latch_q) | (~dir_q & pin_sync);
            default:  rd_value = '0;
        endcase
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int W         = 8,
    parameter int ADDR_W    = 13,
    parameter int DATA_BASE = 0,
    parameter int DIR_BASE  = 4,
    parameter int PORT_IDX  = 0,
    parameter int SYNC_LEN  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    output logic              bus_rvalid,
    input  logic [W-1:0]      pin_in,
    output logic [W-1:0]      pin_out,
    output logic [W-1:0]      pin_oe
);
    localparam logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(DATA_BASE + PORT_IDX);
    localparam logic [ADDR_W-1:0] DIR_ADDR  = ADDR_W'(DIR_BASE + PORT_IDX);

    reg_sel_e     sel;
    logic         rd_acc;
    logic [W-1:0] latch_q, dir_q, pin_sync, rd_value;
    rd_state_e    state, state_nx;

    // Address decode
    always_comb begin
        if (!bus_sel)                  sel = SEL_NONE;
        else if (bus_addr == DATA_ADDR) sel = SEL_DATA;
        else if (bus_addr == DIR_ADDR)  sel = SEL_DIR;
        else                           sel = SEL_NONE;
    end
    assign rd_acc = (sel != SEL_NONE) && !bus_wr;

    gpio_regs #(.W(W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_data (bus_wr && sel == SEL_DATA),
        .wr_dir  (bus_wr && sel == SEL_DIR),
        .wdata   (bus_wdata),
        .latch_q (latch_q),
        .dir_q   (dir_q)
    );

    gpio_sync #(.W(W), .STAGES(SYNC_LEN)) u_sync (
        .clk (clk),
        .d   (pin_in),
        .q   (pin_sync)
    );

    gpio_rdmux #(.W(W)) u_mux (
        .sel      (sel),
        .latch_q  (latch_q),
        .dir_q    (dir_q),
        .pin_sync (pin_sync),
        .rd_value (rd_value)
    );

    // Read controller: next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (rd_acc) state_nx = ST_RESP;   // GO_RESP
            ST_RESP: state_nx = rd_acc ? ST_RESP        // STAY_RESP
                                       : ST_IDLE;       // BACK_IDLE
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register and read data capture
    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            bus_rdata <= '0;
        end else begin
            state <= state_nx;
            if (rd_acc) bus_rdata <= rd_value;
        end
    end

    // Outputs
    always_comb begin
        bus_rvalid = (state == ST_RESP);
        pin_out    = latch_q;
        pin_oe     = dir_q;
    end

    p_oe_follow_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr == DIR_ADDR) |=> pin_oe == $past(bus_wdata))
        else $error("direction write not reflected");

    p_resp_after_read_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && (bus_addr == DATA_ADDR || bus_addr == DIR_ADDR))
        |=> bus_rvalid)
        else $error("missing read response");

    p_no_spurious_resp_r7: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && !bus_wr && (bus_addr == DATA_ADDR || bus_addr == DIR_ADDR))
        |=> !bus_rvalid)
        else $error("unexpected read response");

    p_miss_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && bus_wr && (bus_addr == DATA_ADDR || bus_addr == DIR_ADDR))
        |=> $stable(pin_oe))
        else $error("direction changed without a write");
endmodule

// File: tb/sim_gpio_port.sv
module sim_gpio_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [12:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  pin_in0 = '0, pin_in1 = '0;
    logic [7:0]  rdata0, rdata1, pout0, pout1, poe0, poe1;
    logic        rv0, rv1;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    gpio_port #(.PORT_IDX(0)) u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata0),
        .bus_rvalid(rv0), .pin_in(pin_in0), .pin_out(pout0), .pin_oe(poe0));

    gpio_port #(.PORT_IDX(1)) u1 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata1),
        .bus_rvalid(rv1), .pin_in(pin_in1), .pin_out(pout1), .pin_oe(poe1));

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // Caller is aligned to a falling edge; returns one falling edge later
    task automatic bus_write(input logic [12:0] a, input logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [12:0] a, input logic [7:0] exp, input string req);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(req);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && (rv0 || rv1)) begin
            check("R6 single responder", 8'(rv0 && rv1), 8'h00);
            if (exp_q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R6/R7: unexpected response actual %02h expected none",
                         rv0 ? rdata0 : rdata1);
            end else begin
                check(tag_q.pop_front(), rv0 ? rdata0 : rdata1, exp_q.pop_front());
            end
        end
    end

    task automatic finish_run;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        idle(3);
        // R1: reset state
        check("R1 oe0", poe0, 8'h00);
        check("R1 oe1", poe1, 8'h00);
        check("R1 rvalid", 8'(rv0 | rv1), 8'h00);
        rst = 1'b0;
        idle(1);

        // R5 and R1: direction reads back as zero
        bus_read(13'h0004, 8'h00, "R5 dir0 after reset");
        idle(1);

        // R4: all inputs
        pin_in0 = 8'hA5;
        idle(4);
        bus_read(13'h0000, 8'hA5, "R4 all-input read");
        idle(1);

        // R3: write in input mode loads latch, pin still read
        bus_write(13'h0000, 8'h3C);
        check("R7 no response to write", 8'(rv0 | rv1), 8'h00);
        check("R3 latch on pin_out", pout0, 8'h3C);
        check("R3 oe stays input", poe0, 8'h00);
        bus_read(13'h0000, 8'hA5, "R3 input bits read pins");
        idle(1);

        // R2 / R10: switch high nibble to output
        bus_write(13'h0004, 8'hF0);
        check("R2 oe mask", poe0, 8'hF0);
        check("R10 latched value driven", pout0, 8'h3C);
        bus_read(13'h0000, 8'h35, "R4 mixed read");
        bus_read(13'h0004, 8'hF0, "R5 dir readback");
        idle(1);

        // R6: second port at its own addresses
        bus_write(13'h0001, 8'h81);
        bus_write(13'h0005, 8'hFF);
        check("R6 port1 oe", poe1, 8'hFF);
        check("R6 port1 out", pout1, 8'h81);
        check("R6 port0 out untouched", pout0, 8'h3C);
        check("R6 port0 oe untouched", poe0, 8'hF0);
        bus_read(13'h0001, 8'h81, "R6 port1 data");
        idle(1);

        // R6: unmapped addresses ignored
        bus_write(13'h0002, 8'hFF);
        bus_write(13'h0104, 8'h0F);
        bus_write(13'h0006, 8'h00);
        check("R6 miss out0", pout0, 8'h3C);
        check("R6 miss oe0", poe0, 8'hF0);
        check("R6 miss out1", pout1, 8'h81);
        check("R6 miss oe1", poe1, 8'hFF);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 13'h0003;
        idle(1);
        bus_sel = 1'b0;
        idle(2);

        // R8 + R7: pin change, three back-to-back reads
        pin_in0 = 8'h0A;
        bus_read(13'h0000, 8'h35, "R8 first edge old");
        bus_read(13'h0000, 8'h35, "R8 second edge old");
        bus_read(13'h0000, 8'h3A, "R8 third edge new");
        idle(2);

        // R9: latch survives reset
        bus_write(13'h0000, 8'h5A);
        rst = 1'b1;
        idle(2);
        check("R1 oe after reset", poe0, 8'h00);
        check("R9 latch kept", pout0, 8'h5A);
        rst = 1'b0;
        idle(1);
        bus_write(13'h0004, 8'hFF);
        check("R10 drive after reset", pout0, 8'h5A);
        bus_read(13'h0000, 8'h5A, "R9 data read all-output");
        idle(3);

        if (exp_q.size() != 0) begin
            n_chk++; n_bad++;
            $display("FAIL R7: actual %0d pending expected 0 pending", exp_q.size());
        end
        done = 1'b1;
        finish_run();
    end
endmodule